// File: doc/BRIEF.md
# Two-Port Semaphore Flag Unit

This block keeps a small set of hardware semaphore tokens that two independent ports share, so that software on each side can claim and hand back a shared resource without touching main memory. Each port reaches the tokens by pulling its semaphore select low while its memory chip enable is inactive. The low address bits choose a token. A write supplies a request value on data bit 0. A read returns the token's state, as that port sees it, on every data bit.

Each token is a request/grant object rather than a storage bit. Writing 0 asks for the token. Writing 1 gives it back, or withdraws a request that has not been granted yet. A port reads 0 while it holds the token and 1 at every other time. A request made while the other port holds the token waits and is granted when that port releases it. The unit runs on one clock. It registers each port's read/write line, so a write happens on the cycle where the sampled line rises. Read data and the error flag appear one cycle after the access is sampled.

Top module: `sem_flag_unit`

## Requirements
- R1: After a synchronous active-low reset every token is free, and a read of any token from either port returns 8'hFF.
- R2: A read is taken at a clock edge where select is low, chip enable is low, read/write is 1 and output enable is low. On the next cycle dout_vld is 1 and dout holds the token value for that port, copied into all eight bits (8'h00 = held by this port, 8'hFF = not held by this port).
- R3: A write takes effect only at the edge where read/write is sampled 1 after being sampled 0 on the previous edge, with select low and chip enable low. Holding read/write at 1 writes nothing further. Only data bit 0 is used.
- R4: Address bits [2:0] choose one of eight tokens. Higher address bits are ignored, and a write changes no other token.
- R5: A port that writes 0 to a free token is granted it. That port then reads 8'h00 and the other port reads 8'hFF.
- R6: A port that writes 0 to a token the other port holds keeps reading 8'hFF. When the holder writes 1, ownership passes to the waiting port, which then reads 8'h00.
- R7: When the holder writes 1 and no request is waiting, the token becomes free and both ports read 8'hFF.
- R8: If both ports write 0 to the same free token at the same edge, the left port is granted it and the right port's request waits.
- R9: Select low together with chip enable high is illegal. That port's err output is 1 on the next cycle, no read data is produced, and no token changes.
- R10: A waiting port that writes 1 withdraws its request, so a later release by the holder frees the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_mem_ce | input | 1 | Left memory chip enable, 1 = active |
| l_rw | input | 1 | Left read/write, 1 = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | BUS_ADDR_W | Left address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data |
| l_dout_vld | output | 1 | Left read data valid |
| l_err | output | 1 | Left illegal access flag |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_mem_ce | input | 1 | Right memory chip enable, 1 = active |
| r_rw | input | 1 | Right read/write, 1 = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | BUS_ADDR_W | Right address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data |
| r_dout_vld | output | 1 | Right read data valid |
| r_err | output | 1 | Right illegal access flag |

## Verification
The bench builds the unit with its default parameters: eight tokens, an 8-bit data bus and a 17-bit address. With these values it can reach both the lowest and the highest token index, and it can drive addresses with high bits set that must be ignored. The eight-bit data width shows whether a read copies the token value into every bit and whether writes use bit 0 alone. Together these cover the hand-over, withdrawal and equal-time request cases on real token indices, next to tokens that must stay untouched.

// File: rtl/sem_pkg.sv
// Shared types and the token update rule for the semaphore flag unit.
// Assumes exactly two ports, left = 0 and right = 1.
package sem_pkg;

    localparam logic PORT_L = 1'b0;
    localparam logic PORT_R = 1'b1;

    // Operation decoded for one port in one cycle.
    typedef enum logic [1:0] {
        SEM_IDLE = 2'd0,
        SEM_RD   = 2'd1,
        SEM_WR   = 2'd2,
        SEM_BAD  = 2'd3
    } sem_op_e;

    // State of one token: holder, and a waiting request per port.
    typedef struct packed {
        logic       held;
        logic       owner;
        logic [1:0] waiting;
    } sem_tok_t;

    // Apply one write of value b from port p to token s.
    function automatic sem_tok_t sem_apply(sem_tok_t s, logic p, logic b);
        sem_tok_t n;
        logic     q;
        n = s;
        q = p ^ 1'b1;
        if (!b) begin
            if (!s.held) begin
                n.held  = 1'b1;
                n.owner = p;
            end else if (s.owner != p) begin
                n.waiting[p] = 1'b1;
            end
        end else begin
            n.waiting[p] = 1'b0;
            if (s.held && s.owner == p) begin
                if (s.waiting[q]) begin
                    n.owner      = q;
                    n.waiting[q] = 1'b0;
                end else begin
                    n.held = 1'b0;
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
// Access decoder for one port.
// Classifies the port's control lines into idle, read, write or illegal.
// A write needs a rising read/write line as seen between two clock edges.
// Assumes the control inputs are already synchronous to clk.
module sem_port_decode
    import sem_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_n,
    input  logic    mem_ce,
    input  logic    rw,
    input  logic    oe_n,
    output sem_op_e op
);

    logic rw_q;

    // Remember last sampled read/write level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rw_q <= 1'b1;
        else        rw_q <= rw;
    end

    // Classify this cycle's access.
    always_comb begin
        op = SEM_IDLE;
        if (!sel_n) begin
            if (mem_ce)                  op = SEM_BAD;
            else if (rw && !rw_q)        op = SEM_WR;
            else if (rw && !oe_n)        op = SEM_RD;
        end
    end

    // R3: a write is never decoded unless read/write was low one edge before.
    a_r3_write_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SEM_WR) |-> ($past(rw) == 1'b0));

endmodule

// File: rtl/sem_flag_cell.sv
// One semaphore token shared by two ports.
// Left write is applied before right write in the same cycle, giving left
// priority on a free token. Outputs give each port's view: 0 = held by it.
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_l,
    input  logic bit_l,
    input  logic wr_r,
    input  logic bit_r,
    output logic view_l,
    output logic view_r
);

    sem_tok_t st, st_mid, st_nxt;

    // Next state: apply left write, then right write.
    always_comb begin
        st_mid = wr_l ? sem_apply(st, PORT_L, bit_l) : st;
        st_nxt = wr_r ? sem_apply(st_mid, PORT_R, bit_r) : st_mid;
    end

    // Token register, free after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= st_nxt;
    end

    // Per-port view of the token.
    assign view_l = !(st.held && st.owner == PORT_L);
    assign view_r = !(st.held && st.owner == PORT_R);

    // R5: a lone left request on a free token is granted.
    a_r5_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.held && wr_l && !bit_l && !wr_r) |=> (!view_l && view_r));

    // R8: equal-time requests on a free token go to the left port.
    a_r8_left_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.held && wr_l && !bit_l && wr_r && !bit_r)
        |=> (!view_l && view_r && st.waiting[PORT_R]));

    // R6: release by the left holder hands over to a waiting right port.
    a_r6_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_l && st.waiting[PORT_R] && wr_l && bit_l && !wr_r)
        |=> (!view_r && view_l));

    // R7: release with nobody waiting frees the token.
    a_r7_release_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_r && !st.waiting[PORT_L] && wr_r && bit_r && !wr_l)
        |=> (view_l && view_r));

endmodule

// File: rtl/sem_flag_unit.sv
// Two-port semaphore flag unit.
// Decodes each port, routes writes to the addressed token and registers
// read data and the illegal-access flag for one cycle.
// Assumes both ports are synchronous to clk.
module sem_flag_unit
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS  = 8,
    parameter int DATA_W     = 8,
    parameter int BUS_ADDR_W = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  l_sel_n,
    input  logic                  l_mem_ce,
    input  logic                  l_rw,
    input  logic                  l_oe_n,
    input  logic [BUS_ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0]     l_din,
    output logic [DATA_W-1:0]     l_dout,
    output logic                  l_dout_vld,
    output logic                  l_err,
    input  logic                  r_sel_n,
    input  logic                  r_mem_ce,
    input  logic                  r_rw,
    input  logic                  r_oe_n,
    input  logic [BUS_ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0]     r_din,
    output logic [DATA_W-1:0]     r_dout,
    output logic                  r_dout_vld,
    output logic                  r_err
);

    localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;
    localparam int NP    = 2;

    logic                  sel_n [NP];
    logic                  ce    [NP];
    logic                  rw    [NP];
    logic                  oe_n  [NP];
    logic [BUS_ADDR_W-1:0] addr  [NP];
    logic [DATA_W-1:0]     din   [NP];
    sem_op_e               op    [NP];
    logic [IDX_W-1:0]      idx   [NP];
    logic [NUM_FLAGS-1:0]  wr_hit[NP];
    logic [NUM_FLAGS-1:0]  view  [NP];
    logic [DATA_W-1:0]     dout_q[NP];
    logic                  vld_q [NP];
    logic                  err_q [NP];
    logic                  unused_bits;

    // Gather port pins into arrays.
    always_comb begin
        sel_n[0] = l_sel_n;  sel_n[1] = r_sel_n;
        ce[0]    = l_mem_ce; ce[1]    = r_mem_ce;
        rw[0]    = l_rw;     rw[1]    = r_rw;
        oe_n[0]  = l_oe_n;   oe_n[1]  = r_oe_n;
        addr[0]  = l_addr;   addr[1]  = r_addr;
        din[0]   = l_din;    din[1]   = r_din;
    end

    assign unused_bits = ^{l_addr[BUS_ADDR_W-1:IDX_W], r_addr[BUS_ADDR_W-1:IDX_W],
                           l_din[DATA_W-1:1], r_din[DATA_W-1:1]};

    genvar p, f;
    generate
        for (p = 0; p < NP; p++) begin : g_port
            sem_port_decode u_dec (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel_n  (sel_n[p]),
                .mem_ce (ce[p]),
                .rw     (rw[p]),
                .oe_n   (oe_n[p]),
                .op     (op[p])
            );

            assign idx[p] = addr[p][IDX_W-1:0];

            // Register read data, valid and error for this port.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dout_q[p] <= '0;
                    vld_q[p]  <= 1'b0;
                    err_q[p]  <= 1'b0;
                end else begin
                    vld_q[p]  <= (op[p] == SEM_RD);
                    err_q[p]  <= (op[p] == SEM_BAD);
                    dout_q[p] <= (op[p] == SEM_RD) ? {DATA_W{view[p][idx[p]]}} : '0;
                end
            end

            for (f = 0; f < NUM_FLAGS; f++) begin : g_hit
                assign wr_hit[p][f] = (op[p] == SEM_WR) && (idx[p] == IDX_W'(f));
            end
        end

        for (f = 0; f < NUM_FLAGS; f++) begin : g_flag
            sem_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_l   (wr_hit[0][f]),
                .bit_l  (din[0][0]),
                .wr_r   (wr_hit[1][f]),
                .bit_r  (din[1][0]),
                .view_l (view[0][f]),
                .view_r (view[1][f])
            );
        end
    endgenerate

    assign l_dout     = dout_q[0];
    assign l_dout_vld = vld_q[0];
    assign l_err      = err_q[0];
    assign r_dout     = dout_q[1];
    assign r_dout_vld = vld_q[1];
    assign r_err      = err_q[1];

    // R9: an illegal access never produces read data.
    a_r9_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (l_err |-> !l_dout_vld) and (r_err |-> !r_dout_vld));

    // R2: valid read data is one value copied into every bit.
    a_r2_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
        l_dout_vld |-> (l_dout == '0 || l_dout == '1));

    // R9: an illegal cycle on a port leaves that port's tokens unchanged.
    a_r9_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (op[0] == SEM_BAD && op[1] == SEM_IDLE) |=> $stable(view[0]));

endmodule

// File: tb/test_sem_flag_unit.sv
// Scoreboard bench: driver tasks queue expected reads, a monitor compares.
module test_sem_flag_unit;

    localparam int DW = 8;
    localparam int AW = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          l_sel_n = 1, l_mem_ce = 0, l_rw = 1, l_oe_n = 1;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_din = '0;
    logic          r_sel_n = 1, r_mem_ce = 0, r_rw = 1, r_oe_n = 1;
    logic [AW-1:0] r_addr = '0;
    logic [DW-1:0] r_din = '0;
    logic [DW-1:0] l_dout, r_dout;
    logic          l_dout_vld, r_dout_vld, l_err, r_err;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_l[$];
    logic [15:0] exp_r[$];

    always #5 clk = ~clk;

    sem_flag_unit #(.NUM_FLAGS(8), .DATA_W(DW), .BUS_ADDR_W(AW)) i_sem_flag_unit (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_mem_ce(l_mem_ce), .l_rw(l_rw), .l_oe_n(l_oe_n),
        .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_dout_vld(l_dout_vld),
        .l_err(l_err),
        .r_sel_n(r_sel_n), .r_mem_ce(r_mem_ce), .r_rw(r_rw), .r_oe_n(r_oe_n),
        .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_dout_vld(r_dout_vld),
        .r_err(r_err)
    );

    task automatic report(input bit ok, input int req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected read data whenever valid appears.
    always @(negedge clk) begin
        if (rst_n && l_dout_vld) begin
            if (exp_l.size() == 0) report(0, 9, l_dout, 16'hDEAD);
            else begin
                logic [15:0] e;
                e = exp_l.pop_front();
                report(l_dout == e[7:0], int'(e[15:8]), l_dout, e[7:0]);
            end
        end
        if (rst_n && r_dout_vld) begin
            if (exp_r.size() == 0) report(0, 9, r_dout, 16'hDEAD);
            else begin
                logic [15:0] e;
                e = exp_r.pop_front();
                report(r_dout == e[7:0], int'(e[15:8]), r_dout, e[7:0]);
            end
        end
    end

    task automatic drive(input bit p, input logic sel_n, input logic ce, input logic rw,
                         input logic oe_n, input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (!p) begin
            l_sel_n = sel_n; l_mem_ce = ce; l_rw = rw; l_oe_n = oe_n; l_addr = a; l_din = d;
        end else begin
            r_sel_n = sel_n; r_mem_ce = ce; r_rw = rw; r_oe_n = oe_n; r_addr = a; r_din = d;
        end
    endtask

    // Read token a from port p, expecting value e.
    task automatic rd(input bit p, input logic [AW-1:0] a, input logic [7:0] e, input int req);
        @(negedge clk);
        drive(p, 0, 0, 1, 0, a, '0);
        if (!p) exp_l.push_back({8'(req), e});
        else    exp_r.push_back({8'(req), e});
        @(negedge clk);
        drive(p, 1, 0, 1, 1, a, '0);
    endtask

    // Write d through port p (p=2: both ports at once).
    task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        if (p != 1) drive(0, 0, 0, 0, 1, a, d);
        if (p != 0) drive(1, 0, 0, 0, 1, a, d);
        @(negedge clk);
        if (p != 1) l_rw = 1;
        if (p != 0) r_rw = 1;
        @(negedge clk);
        if (p != 1) drive(0, 1, 0, 1, 1, '0, '0);
        if (p != 0) drive(1, 1, 0, 1, 1, '0, '0);
    endtask

    bit done = 0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        report(l_dout_vld == 0 && l_err == 0 && r_err == 0, 1, l_dout_vld, 0);
        // R1: all free after reset
        rd(0, 0, 8'hFF, 1); rd(1, 0, 8'hFF, 1); rd(1, 7, 8'hFF, 1);
        // R5 and R4: left claims token 3 via address with high bits set
        wr(0, 17'h1FFFB, 8'hFE);
        rd(0, 3, 8'h00, 5); rd(1, 3, 8'hFF, 5); rd(0, 2, 8'hFF, 4);
        // R3: only bit 0 matters; held read/write does not write again
        wr(1, 5, 8'hFE);
        @(negedge clk); drive(1, 0, 0, 1, 1, 5, 8'h01);
        repeat (3) @(negedge clk);
        drive(1, 1, 0, 1, 1, 0, 0);
        rd(1, 5, 8'h00, 3);
        // R6: right waits on token 3, left releases, right takes over
        wr(1, 3, 8'h00);
        rd(1, 3, 8'hFF, 6);
        wr(0, 3, 8'hFF);
        rd(1, 3, 8'h00, 6); rd(0, 3, 8'hFF, 6);
        // R10: left waits then withdraws; right release frees token
        wr(0, 3, 8'h00); wr(0, 3, 8'h01); wr(1, 3, 8'h01);
        rd(0, 3, 8'hFF, 10); rd(1, 3, 8'hFF, 10);
        // R7: right frees token 5
        wr(1, 5, 8'h01);
        rd(0, 5, 8'hFF, 7); rd(1, 5, 8'hFF, 7);
        // R8: equal-time requests on token 7
        wr(2, 7, 8'h00);
        rd(0, 7, 8'h00, 8); rd(1, 7, 8'hFF, 8);
        wr(0, 7, 8'h01);
        rd(1, 7, 8'h00, 8);
        wr(1, 7, 8'h01);
        // R9: illegal access on left: error flag, no data, no write
        @(negedge clk); drive(0, 0, 1, 0, 0, 1, 8'h00);
        @(negedge clk); report(l_err == 1, 9, l_err, 1); l_rw = 1;
        @(negedge clk); report(l_err == 1, 9, l_err, 1); drive(0, 1, 0, 1, 1, 0, 0);
        @(negedge clk); report(l_err == 0 && r_err == 0, 9, l_err, 0);
        rd(0, 1, 8'hFF, 9); rd(1, 1, 8'hFF, 9);
        repeat (3) @(negedge clk);
        report(exp_l.size() == 0 && exp_r.size() == 0, 2, exp_l.size() + exp_r.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                report(0, 0, 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule